// File: doc/BRIEF.md
# Serial Peripheral Interrupt Controller

This block gathers the interrupt sources of a serial peripheral and presents them to software through a small register bus. Seven sources are tracked. Three are events (receive overflow, mode fault, transmit underflow) that are latched until software reads the status register. The other four are live FIFO levels that always show the present state of the FIFOs: transmit not full, transmit full, receive not empty and receive full.

Software controls which sources reach the single interrupt line through a mask. The mask cannot be written directly. A write-1-to-set register turns mask bits on, and a write-1-to-clear register turns them off. Zero bits in either write leave the matching mask bits unchanged, so separate drivers can own separate sources without a read-modify-write sequence.

The interrupt output is high whenever some status bit and its mask bit are both 1. The FIFOs and the shift engine are outside this block. They supply the level inputs and the event pulses.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every mask bit is 0, every sticky status bit is 0 and `irq_o` is 0.
- R2: A write to offset 0x8 sets each mask bit whose write-data bit is 1 and leaves every mask bit whose write-data bit is 0 unchanged, from the next cycle.
- R3: A write to offset 0xC clears each mask bit whose write-data bit is 1 and leaves every mask bit whose write-data bit is 0 unchanged, from the next cycle.
- R4: A read at offset 0x10 returns the mask in bits [6:0]. Writes to 0x10 and to 0x4 change nothing. Reads at 0x8, 0xC or any unmapped offset return 0. `rdata_o` is 0 whenever `rd_i` is low, and bits above 6 always read 0.
- R5: Status bits 2, 3, 4 and 5 show the present levels: bit 2 = not `tx_full_i`, bit 3 = `tx_full_i`, bit 4 = not `rx_empty_i`, bit 5 = `rx_full_i`. They are not latched.
- R6: Status bit 0 (receive overflow) becomes 1 in the cycle after a cycle with `rx_push_i` and `rx_full_i` both high. A push while the receive FIFO is not full leaves it unchanged.
- R7: Status bit 1 (mode fault) is set by a `mode_fail_i` pulse, and status bit 6 (transmit underflow) is set by a `tx_underflow_i` pulse. Each stays set without a status read.
- R8: A read at offset 0x4 returns the status in the same cycle. It clears bits 0, 1 and 6 at that clock edge, except a bit whose event arrives in the same cycle as the read, which stays set.
- R9: `irq_o` is high exactly when some status bit and its mask bit are both 1. It follows the status and mask combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 7 | Write data, one bit per source |
| rdata_o | output | DATA_W | Read data, combinational |
| tx_full_i | input | 1 | Transmit FIFO full level |
| rx_empty_i | input | 1 | Receive FIFO empty level |
| rx_full_i | input | 1 | Receive FIFO full level |
| rx_push_i | input | 1 | Receive FIFO push attempt |
| mode_fail_i | input | 1 | Mode fault event pulse |
| tx_underflow_i | input | 1 | Transmit underflow event pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted mask bit shows up on the next mask read-back and, when the matching status bit is 1, on `irq_o` in the same cycle. A sticky flag that was lost or cleared too early shows up at the next status read. A flag that failed to clear shows up on the read after that. The case of an event arriving in the same cycle as a read is driven on purpose, because a wrong clear priority is only visible on the second read.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
  localparam int unsigned SRC_N = 7;

  // source bit positions (software decodes these)
  localparam int unsigned SRC_RX_OVF    = 0;
  localparam int unsigned SRC_MODE_FAIL = 1;
  localparam int unsigned SRC_TX_NFULL  = 2;
  localparam int unsigned SRC_TX_FULL   = 3;
  localparam int unsigned SRC_RX_NEMPTY = 4;
  localparam int unsigned SRC_RX_FULL   = 5;
  localparam int unsigned SRC_TX_UNDER  = 6;

  localparam logic [SRC_N-1:0] STICKY_SRC = 7'b100_0011;

  localparam int unsigned OFS_STATUS  = 'h04;
  localparam int unsigned OFS_ENABLE  = 'h08;
  localparam int unsigned OFS_DISABLE = 'h0C;
  localparam int unsigned OFS_MASK    = 'h10;
endpackage

// File: rtl/irq_reg_decode.sv
`timescale 1ns/1ps
module irq_reg_decode
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N      = SRC_N
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [N-1:0]      status_i,
  input  logic [N-1:0]      mask_i,
  output logic              stat_rd_o,
  output logic              en_wr_o,
  output logic              dis_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DISABLE);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

  logic hit_stat, hit_en, hit_dis, hit_mask;

  assign hit_stat = (addr_i == A_STAT);
  assign hit_en   = (addr_i == A_EN);
  assign hit_dis  = (addr_i == A_DIS);
  assign hit_mask = (addr_i == A_MASK);

  assign stat_rd_o = rd_i & hit_stat;
  assign en_wr_o   = wr_i & hit_en;
  assign dis_wr_o  = wr_i & hit_dis;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (hit_stat)      rdata_o[N-1:0] = status_i;
      else if (hit_mask) rdata_o[N-1:0] = mask_i;
    end
  end
endmodule

// File: rtl/irq_status.sv
`timescale 1ns/1ps
module irq_status #(
  parameter int unsigned      N      = 7,
  parameter logic [N-1:0]     STICKY = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,   // event pulse on sticky bits, level elsewhere
  input  logic         clr_i,
  output logic [N-1:0] status_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (STICKY[i]) begin : g_sticky
      logic flag_q;
      // set wins over clear-on-read
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= (flag_q & ~clr_i) | src_i[i];
      end
      assign status_o[i] = flag_q;
    end else begin : g_live
      assign status_o[i] = src_i[i];
    end
  end
endmodule

// File: rtl/irq_mask.sv
`timescale 1ns/1ps
module irq_mask #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (set_i) mask_q <= mask_q | bits_i;
    else if (clr_i) mask_q <= mask_q & ~bits_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [SRC_N-1:0]  wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tx_full_i,
  input  logic              rx_empty_i,
  input  logic              rx_full_i,
  input  logic              rx_push_i,
  input  logic              mode_fail_i,
  input  logic              tx_underflow_i,
  output logic              irq_o
);
  logic [SRC_N-1:0] src_w, status_w, mask_w;
  logic             stat_rd_w, en_wr_w, dis_wr_w;

  always_comb begin
    src_w                = '0;
    src_w[SRC_RX_OVF]    = rx_push_i & rx_full_i;
    src_w[SRC_MODE_FAIL] = mode_fail_i;
    src_w[SRC_TX_NFULL]  = ~tx_full_i;
    src_w[SRC_TX_FULL]   = tx_full_i;
    src_w[SRC_RX_NEMPTY] = ~rx_empty_i;
    src_w[SRC_RX_FULL]   = rx_full_i;
    src_w[SRC_TX_UNDER]  = tx_underflow_i;
  end

  irq_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(SRC_N)) i_dec (
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .status_i (status_w),
    .mask_i   (mask_w),
    .stat_rd_o(stat_rd_w),
    .en_wr_o  (en_wr_w),
    .dis_wr_o (dis_wr_w),
    .rdata_o  (rdata_o)
  );

  irq_status #(.N(SRC_N), .STICKY(STICKY_SRC)) i_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_w),
    .clr_i   (stat_rd_w),
    .status_o(status_w)
  );

  irq_mask #(.N(SRC_N)) i_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (en_wr_w),
    .clr_i (dis_wr_w),
    .bits_i(wdata_i),
    .mask_o(mask_w)
  );

  assign irq_o = |(status_w & mask_w);
endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [SRC_N-1:0]  wdata_i,
  input logic              tx_full_i,
  input logic              rx_full_i,
  input logic              rx_push_i,
  input logic              tx_underflow_i,
  input logic [SRC_N-1:0]  status_w,
  input logic [SRC_N-1:0]  mask_w,
  input logic              irq_o
);
  logic en_wr, dis_wr, mask_wr, stat_rd;
  assign en_wr   = wr_i && (addr_i == ADDR_W'(OFS_ENABLE));
  assign dis_wr  = wr_i && (addr_i == ADDR_W'(OFS_DISABLE));
  assign mask_wr = wr_i && (addr_i == ADDR_W'(OFS_MASK));
  assign stat_rd = rd_i && (addr_i == ADDR_W'(OFS_STATUS));

  // R2
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr |=> ((mask_w & $past(wdata_i)) == $past(wdata_i)) &&
              ((mask_w & ~$past(wdata_i)) == ($past(mask_w) & ~$past(wdata_i))));
  // R3
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_wr |=> ((mask_w & $past(wdata_i)) == '0) &&
               ((mask_w & ~$past(wdata_i)) == ($past(mask_w) & ~$past(wdata_i))));
  // R4
  mask_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr |=> $stable(mask_w));
  // R5
  live_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_w[SRC_TX_FULL] != status_w[SRC_TX_NFULL] && status_w[SRC_TX_FULL] == tx_full_i);
  // R6
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_full_i) |=> status_w[SRC_RX_OVF]);
  // R7
  under_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_w[SRC_TX_UNDER] && !stat_rd) |=> status_w[SRC_TX_UNDER]);
  // R8
  under_race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && tx_underflow_i) |=> status_w[SRC_TX_UNDER]);
  // R8
  read_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !tx_underflow_i) |=> !status_w[SRC_TX_UNDER]);
  // R9
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_w == '0) |-> !irq_o);
endmodule

bind irq_ctrl irq_ctrl_chk #(.ADDR_W(ADDR_W)) i_irq_ctrl_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .wr_i          (wr_i),
  .rd_i          (rd_i),
  .wdata_i       (wdata_i),
  .tx_full_i     (tx_full_i),
  .rx_full_i     (rx_full_i),
  .rx_push_i     (rx_push_i),
  .tx_underflow_i(tx_underflow_i),
  .status_w      (status_w),
  .mask_w        (mask_w),
  .irq_o         (irq_o)
);

// File: tb/test_irq_ctrl.sv
`timescale 1ns/1ps
module test_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [6:0]  wdata = '0;
  logic [31:0] rdata;
  logic        tx_full = 1'b0, rx_empty = 1'b1, rx_full = 1'b0;
  logic        rx_push = 1'b0, mode_fail = 1'b0, tx_under = 1'b0;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .tx_full_i(tx_full), .rx_empty_i(rx_empty),
    .rx_full_i(rx_full), .rx_push_i(rx_push), .mode_fail_i(mode_fail),
    .tx_underflow_i(tx_under), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0] addr;
    logic [6:0] wdata;
    logic [6:0] mask;
    logic       irq;
  } vec_t;

  // status holds 0x04 (TX not full) throughout, so irq follows mask bit 2
  localparam vec_t VEC [10] = '{
    '{8'h08, 7'h05, 7'h05, 1'b1},
    '{8'h08, 7'h02, 7'h07, 1'b1},
    '{8'h0C, 7'h01, 7'h06, 1'b1},
    '{8'h08, 7'h00, 7'h06, 1'b1},
    '{8'h0C, 7'h00, 7'h06, 1'b1},
    '{8'h08, 7'h78, 7'h7E, 1'b1},
    '{8'h10, 7'h00, 7'h7E, 1'b1},
    '{8'h0C, 7'h04, 7'h7A, 1'b0},
    '{8'h04, 7'h7F, 7'h7A, 1'b0},
    '{8'h0C, 7'h7F, 7'h00, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [6:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #2 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    bus_read(8'h10, d); check("R1 mask after reset", d, 32'h0);
    bus_read(8'h04, d); check("R1 status after reset", d, 32'h04);

    // R2 R3 R4 R9 mask table
    foreach (VEC[i]) begin
      string tg;
      tg = (VEC[i].addr == 8'h08) ? "R2" : (VEC[i].addr == 8'h0C) ? "R3" : "R4";
      bus_write(VEC[i].addr, VEC[i].wdata);
      bus_read(8'h10, d);
      check({tg, " mask vector"}, d, {25'd0, VEC[i].mask});
      check("R9 irq vector", {31'd0, irq}, {31'd0, VEC[i].irq});
    end

    // R4 write-only, unmapped and idle reads
    bus_write(8'h08, 7'h55);
    bus_read(8'h08, d); check("R4 enable reads zero", d, 32'h0);
    bus_read(8'h0C, d); check("R4 disable reads zero", d, 32'h0);
    bus_read(8'h18, d); check("R4 unmapped reads zero", d, 32'h0);
    @(negedge clk); addr = 8'h10; #2;
    check("R4 no read strobe", rdata, 32'h0);
    bus_write(8'h0C, 7'h7F);

    // R5 live levels
    @(negedge clk); tx_full = 1'b1;
    bus_read(8'h04, d); check("R5 tx full", d, 32'h08);
    @(negedge clk); rx_empty = 1'b0;
    bus_read(8'h04, d); check("R5 rx not empty", d, 32'h18);
    @(negedge clk); rx_full = 1'b1; tx_full = 1'b0;
    bus_read(8'h04, d); check("R5 rx full", d, 32'h34);
    bus_read(8'h04, d); check("R5 levels not cleared by read", d, 32'h34);

    // R6 overflow
    @(negedge clk); rx_full = 1'b0; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
    bus_read(8'h04, d); check("R6 push not full", d, 32'h14);
    @(negedge clk); rx_full = 1'b1; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
    bus_read(8'h04, d); check("R6 overflow set", d, 32'h35);
    bus_read(8'h04, d); check("R8 overflow cleared", d, 32'h34);
    @(negedge clk); rx_full = 1'b0; rx_empty = 1'b1;

    // R7 mode fail and underflow hold
    @(negedge clk); mode_fail = 1'b1;
    @(negedge clk); mode_fail = 1'b0;
    @(negedge clk); tx_under = 1'b1;
    @(negedge clk); tx_under = 1'b0;
    repeat (5) @(negedge clk);
    bus_write(8'h08, 7'h40);
    check("R9 irq from underflow", {31'd0, irq}, 32'd1);
    bus_read(8'h04, d); check("R7 sticky held", d, 32'h46);
    check("R8 irq drops after read", {31'd0, irq}, 32'd0);
    bus_read(8'h04, d); check("R8 sticky cleared", d, 32'h04);

    // R8 event in the read cycle survives
    @(negedge clk); addr = 8'h04; rd = 1'b1; tx_under = 1'b1; #2 d = rdata;
    check("R8 race read value", d, 32'h04);
    @(negedge clk); rd = 1'b0; tx_under = 1'b0;
    bus_read(8'h04, d); check("R8 race event kept", d, 32'h44);
    bus_read(8'h04, d); check("R8 race cleared later", d, 32'h04);

    // R9 live source through mask
    bus_write(8'h08, 7'h04);
    check("R9 irq live", {31'd0, irq}, 32'd1);
    @(negedge clk); tx_full = 1'b1; #2;
    check("R9 irq follows level", {31'd0, irq}, 32'd0);
    @(negedge clk); tx_full = 1'b0;
    bus_write(8'h0C, 7'h04);
    check("R9 irq masked off", {31'd0, irq}, 32'd0);

    // R1 reset mid-run
    bus_write(8'h08, 7'h7F);
    @(negedge clk); mode_fail = 1'b1;
    @(negedge clk); mode_fail = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bus_read(8'h10, d); check("R1 mask cleared by reset", d, 32'h0);
    bus_read(8'h04, d); check("R1 sticky cleared by reset", d, 32'h04);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule